// File: doc/BRIEF.md
# Interrupt Aggregation Pin Controller

This block gathers the event flags of a USB device function into one interrupt status register. Each flag can be passed on or blocked by a per-bit enable register. All bits that pass are ORed into one request, which drives a single external interrupt pin. Software chooses whether the pin is active high or active low. It also chooses whether the pin holds a level while the request stands or gives one fixed-width pulse each time the request rises.

A host bus with separate read and write strobes reaches the registers. Each register has a write command code, and its read code is that write code plus one. The event sources send one-cycle pulses, and the bus-status input is a live level. A separate strobe carries an endpoint index and marks the read of that endpoint's status. That strobe is the only thing that clears an endpoint flag. A global enable bit masks the request. A separate output-latch bit freezes the pin at whatever value it holds.

Top module: `intr_aggregator`

## Requirements
- R1: After reset the pin is high, which means inactive in the default active-low mode. The enable, mode and status registers read 0 and the configuration register reads 4. Configuration bits: bit 0 is active-high polarity, bit 1 is pulse mode, bit 2 is output-latch enable.
- R2: Write codes are 0x20 for mode (bit 0 is global enable), 0x22 for configuration and 0x24 for enable. The matching read codes are 0x21, 0x23 and 0x25, and status is read at 0x27. Writes are taken on the strobed clock edge. Read data is combinational while the read strobe is high, and is 0 for any other code or when no read is strobed.
- R3: Status bits 0 to 4 are the general events (bus reset, resume, special end-of-transfer, end-of-transfer, start-of-frame). Status bits 6 and up are the endpoint events. An event pulse sets its bit on the clock edge that samples it. An event that arrives on the same edge as a clear of its bit leaves the bit set.
- R4: The request is registered on the edge after the status changes. It equals the global enable ANDed with the OR of the status view ANDed with the enable register. In level mode the pin follows the request one edge later. An event whose enable bit is 0 has no effect on the pin.
- R5: With polarity 1 the pin is high when asserted. With polarity 0 the pin is low when asserted.
- R6: In pulse mode, a 0-to-1 change of the registered request asserts the pin for PULSE_CYCLES cycles, starting three edges after the event edge. A new rise during a pulse neither restarts it nor lengthens it.
- R7: A status read clears bits 0 to 4 on that clock edge. The values returned by the read are the values held before the clear.
- R8: A status read leaves the endpoint bits unchanged. An endpoint-status strobe clears only the bit of the endpoint index it carries.
- R9: Status bit 5 is the bus-status input itself, not a latched copy. When it is enabled it counts toward the request.
- R10: While the output-latch bit is 0, the pin keeps its value through any register activity. When the bit returns to 1, the pin follows the request again.
- R11: With global enable 0 the request is 0, so the pin stays inactive whatever the status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 8 | Command code for the current access |
| wrStrobe | input | 1 | Write access this cycle |
| rdStrobe | input | 1 | Read access this cycle |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data |
| genEvent | input | 5 | General event pulses, one per status bit 0 to 4 |
| epEvent | input | NUM_EP | Endpoint event pulses, status bit 6 + index |
| busStatus | input | 1 | Live bus status level |
| epRdStrobe | input | 1 | Endpoint status register read |
| epIndex | input | EP_IDX_W | Endpoint addressed by epRdStrobe |
| intPin | output | 1 | Interrupt output pin |

## Verification
The assertions assume that a read strobe and a write strobe never come in the same cycle. They also assume that the event inputs are clean single-cycle pulses that are 0 while reset is asserted. The stimulus drives one access at a time from tasks, keeps every event pulse one cycle wide and holds all inputs at 0 during reset. The only deliberate overlap is an event pulse placed on the same edge as a clearing status read, which is the collision case of R3.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int GEN_BITS = 5;
  localparam int BUS_BIT  = 5;
  localparam int EP_BASE  = 6;

  localparam logic [7:0] CMD_MODE_WR = 8'h20;
  localparam logic [7:0] CMD_CFG_WR  = 8'h22;
  localparam logic [7:0] CMD_EN_WR   = 8'h24;
  localparam logic [7:0] CMD_STAT_WR = 8'h26;
  localparam logic [7:0] CMD_MODE_RD = CMD_MODE_WR + 8'd1;
  localparam logic [7:0] CMD_CFG_RD  = CMD_CFG_WR + 8'd1;
  localparam logic [7:0] CMD_EN_RD   = CMD_EN_WR + 8'd1;
  localparam logic [7:0] CMD_STAT_RD = CMD_STAT_WR + 8'd1;

  localparam int CFG_POL   = 0;
  localparam int CFG_PULSE = 1;
  localparam int CFG_LATCH = 2;
  localparam logic [2:0] CFG_RESET = 3'b100;

  typedef struct packed {
    logic wrMode;
    logic wrCfg;
    logic wrEn;
    logic rdMode;
    logic rdCfg;
    logic rdEn;
    logic rdStat;
  } ctrl_strobes_t;
endpackage

// File: rtl/intr_agg_ctrl.sv
module intr_agg_ctrl
  import intr_agg_pkg::*;
#(
  parameter int NUM_EP   = 16,
  parameter int EP_IDX_W = $clog2(NUM_EP)
) (
  input  logic [7:0]          cmd,
  input  logic                wrStrobe,
  input  logic                rdStrobe,
  input  logic                epRdStrobe,
  input  logic [EP_IDX_W-1:0] epIndex,
  output ctrl_strobes_t       strobes,
  output logic [NUM_EP-1:0]   epClr
);
  always_comb begin
    strobes.wrMode = wrStrobe && (cmd == CMD_MODE_WR);
    strobes.wrCfg  = wrStrobe && (cmd == CMD_CFG_WR);
    strobes.wrEn   = wrStrobe && (cmd == CMD_EN_WR);
    strobes.rdMode = rdStrobe && (cmd == CMD_MODE_RD);
    strobes.rdCfg  = rdStrobe && (cmd == CMD_CFG_RD);
    strobes.rdEn   = rdStrobe && (cmd == CMD_EN_RD);
    strobes.rdStat = rdStrobe && (cmd == CMD_STAT_RD);
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : gen_ep_clr
    assign epClr[g] = epRdStrobe && (epIndex == EP_IDX_W'(g));
  end
endmodule

// File: rtl/intr_agg_dp.sv
module intr_agg_dp
  import intr_agg_pkg::*;
#(
  parameter int NUM_EP       = 16,
  parameter int DATA_W       = 32,
  parameter int PULSE_CYCLES = 42,
  parameter int STAT_W       = EP_BASE + NUM_EP,
  parameter int CNT_W        = $clog2(PULSE_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_strobes_t       strobes,
  input  logic [NUM_EP-1:0]   epClr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [GEN_BITS-1:0] genEvent,
  input  logic [NUM_EP-1:0]   epEvent,
  input  logic                busStatus,
  output logic [DATA_W-1:0]   rdData,
  output logic                intPin,
  output logic [STAT_W-1:0]   statQ,
  output logic                reqQ,
  output logic [CNT_W-1:0]    pulseCnt,
  output logic [2:0]          cfgQ,
  output logic                modeQ
);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYCLES);

  logic [STAT_W-1:0] enQ;
  logic [STAT_W-1:0] setVec, clrVec, statD, statView;
  logic              reqD, reqPrevQ, pinActive, pinLevel;

  always_comb begin
    setVec = '0;
    setVec[GEN_BITS-1:0] = genEvent;
    setVec[EP_BASE +: NUM_EP] = epEvent;
    clrVec = '0;
    clrVec[GEN_BITS-1:0] = {GEN_BITS{strobes.rdStat}};
    clrVec[EP_BASE +: NUM_EP] = epClr;
    statD = (statQ & ~clrVec) | setVec;
    statD[BUS_BIT] = 1'b0;
    statView = statQ;
    statView[BUS_BIT] = busStatus;
    reqD = modeQ && |(statView & enQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statQ <= '0;
      enQ   <= '0;
      modeQ <= 1'b0;
      cfgQ  <= CFG_RESET;
    end else begin
      statQ <= statD;
      if (strobes.wrEn)   enQ   <= wrData[STAT_W-1:0];
      if (strobes.wrMode) modeQ <= wrData[0];
      if (strobes.wrCfg)  cfgQ  <= wrData[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqQ     <= 1'b0;
      reqPrevQ <= 1'b0;
      pulseCnt <= '0;
    end else begin
      reqQ     <= reqD;
      reqPrevQ <= reqQ;
      if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
      else if (reqQ && !reqPrevQ)
        pulseCnt <= PULSE_LOAD;
    end
  end

  always_comb begin
    pinActive = cfgQ[CFG_PULSE] ? (pulseCnt != '0) : reqQ;
    pinLevel  = cfgQ[CFG_POL] ? pinActive : !pinActive;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                intPin <= 1'b1;
    else if (cfgQ[CFG_LATCH])  intPin <= pinLevel;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdMode)      rdData = DATA_W'(modeQ);
    else if (strobes.rdCfg)  rdData = DATA_W'(cfgQ);
    else if (strobes.rdEn)   rdData = DATA_W'(enQ);
    else if (strobes.rdStat) rdData = DATA_W'(statView);
  end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_agg_pkg::*;
#(
  parameter int NUM_EP       = 16,
  parameter int DATA_W       = 32,
  parameter int PULSE_CYCLES = 42,
  parameter int EP_IDX_W     = $clog2(NUM_EP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          cmd,
  input  logic                wrStrobe,
  input  logic                rdStrobe,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [GEN_BITS-1:0] genEvent,
  input  logic [NUM_EP-1:0]   epEvent,
  input  logic                busStatus,
  input  logic                epRdStrobe,
  input  logic [EP_IDX_W-1:0] epIndex,
  output logic                intPin
);
  localparam int STAT_W = EP_BASE + NUM_EP;
  localparam int CNT_W  = $clog2(PULSE_CYCLES + 1);

  ctrl_strobes_t     strobes;
  logic [NUM_EP-1:0] epClr;
  logic [STAT_W-1:0] statQ;
  logic              reqQ;
  logic [CNT_W-1:0]  pulseCnt;
  logic [2:0]        cfgQ;
  logic              modeQ;

  intr_agg_ctrl #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_ctrl (
    .cmd(cmd), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .epRdStrobe(epRdStrobe), .epIndex(epIndex),
    .strobes(strobes), .epClr(epClr)
  );

  intr_agg_dp #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .PULSE_CYCLES(PULSE_CYCLES),
                .STAT_W(STAT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .epClr(epClr),
    .wrData(wrData), .genEvent(genEvent), .epEvent(epEvent),
    .busStatus(busStatus), .rdData(rdData), .intPin(intPin),
    .statQ(statQ), .reqQ(reqQ), .pulseCnt(pulseCnt), .cfgQ(cfgQ), .modeQ(modeQ)
  );
endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk
  import intr_agg_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int STAT_W = EP_BASE + NUM_EP,
  parameter int CNT_W  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          cmd,
  input logic                rdStrobe,
  input logic                epRdStrobe,
  input logic [GEN_BITS-1:0] genEvent,
  input logic [NUM_EP-1:0]   epEvent,
  input logic [STAT_W-1:0]   statQ,
  input logic                reqQ,
  input logic [CNT_W-1:0]    pulseCnt,
  input logic [2:0]          cfgQ,
  input logic                modeQ,
  input logic                intPin
);
  logic [STAT_W-1:0] setVec;
  logic [NUM_EP-1:0] epBits;
  assign setVec = {epEvent, 1'b0, genEvent};
  assign epBits = statQ[EP_BASE +: NUM_EP];

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|setVec) |=> ((statQ & $past(setVec)) == $past(setVec)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && cmd == CMD_STAT_RD && genEvent == '0) |=> (statQ[GEN_BITS-1:0] == '0));

  assert_ep_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!epRdStrobe) |=> ((epBits & $past(epBits)) == $past(epBits)));

  assert_global_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeQ) |=> !reqQ);

  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgQ[CFG_LATCH]) |=> $stable(intPin));

  assert_pulse_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseCnt != '0) |=> (pulseCnt == $past(pulseCnt) - 1'b1));

  assert_level_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ == 3'b100) |=> (intPin == !$past(reqQ)));

  assert_level_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ == 3'b101) |=> (intPin == $past(reqQ)));
endmodule

bind intr_aggregator intr_agg_chk #(.NUM_EP(NUM_EP), .STAT_W(STAT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .rdStrobe(rdStrobe), .epRdStrobe(epRdStrobe),
  .genEvent(genEvent), .epEvent(epEvent), .statQ(statQ), .reqQ(reqQ),
  .pulseCnt(pulseCnt), .cfgQ(cfgQ), .modeQ(modeQ), .intPin(intPin)
);

// File: tb/intr_aggregator_test.sv
module intr_aggregator_test;
  localparam int NUM_EP = 16;
  localparam int DATA_W = 32;
  localparam int PULSE  = 42;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        cmd = '0;
  logic              wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [4:0]        genEvent = '0;
  logic [NUM_EP-1:0] epEvent = '0;
  logic              busStatus = 1'b0;
  logic              epRdStrobe = 1'b0;
  logic [IDX_W-1:0]  epIndex = '0;
  logic              intPin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  intr_aggregator #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .PULSE_CYCLES(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .wrData(wrData), .rdData(rdData), .genEvent(genEvent), .epEvent(epEvent),
    .busStatus(busStatus), .epRdStrobe(epRdStrobe), .epIndex(epIndex), .intPin(intPin)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic [21:0] mStat, mEn;
  logic        mMode, mReq, mPrev, mPin;
  logic [2:0]  mCfg;
  int          mCnt;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mStat = '0; mEn = '0; mMode = 0; mCfg = 3'b100;
      mReq = 0; mPrev = 0; mCnt = 0; mPin = 1;
    end else begin
      logic [21:0] view, nStat;
      logic        act, nReq;
      view = mStat; view[5] = busStatus;
      nReq = mMode && ((view & mEn) != 0);
      act = mCfg[1] ? (mCnt != 0) : mReq;
      if (mCfg[2]) mPin = mCfg[0] ? act : !act;
      if (mCnt > 0) mCnt--;
      else if (mReq && !mPrev) mCnt = PULSE;
      mPrev = mReq;
      mReq = nReq;
      nStat = mStat;
      if (rdStrobe && cmd == 8'h27) nStat[4:0] = '0;
      if (epRdStrobe) nStat[6 + epIndex] = 1'b0;
      nStat[4:0] = nStat[4:0] | genEvent;
      nStat[21:6] = nStat[21:6] | epEvent;
      mStat = nStat;
      if (wrStrobe && cmd == 8'h20) mMode = wrData[0];
      if (wrStrobe && cmd == 8'h22) mCfg = wrData[2:0];
      if (wrStrobe && cmd == 8'h24) mEn = wrData[21:0];
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] c);
    logic [21:0] v;
    v = mStat; v[5] = busStatus;
    case (c)
      8'h21:   return {31'b0, mMode};
      8'h23:   return {29'b0, mCfg};
      8'h25:   return {10'b0, mEn};
      8'h27:   return {10'b0, v};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) check(phase, {31'b0, intPin}, {31'b0, mPin});

  task automatic wr(input logic [7:0] c, input logic [31:0] d);
    @(posedge clk); #1 cmd = c; wrData = d; wrStrobe = 1;
    @(posedge clk); #1 wrStrobe = 0;
  endtask

  task automatic rd(input logic [7:0] c, input string tag);
    @(posedge clk); #1 cmd = c; rdStrobe = 1;
    @(negedge clk) check(tag, rdData, expRead(c));
    @(posedge clk); #1 rdStrobe = 0;
  endtask

  task automatic gen(input logic [4:0] g, input logic [15:0] e);
    @(posedge clk); #1 genEvent = g; epEvent = e;
    @(posedge clk); #1 genEvent = '0; epEvent = '0;
  endtask

  task automatic epRead(input int idx);
    @(posedge clk); #1 epIndex = IDX_W'(idx); epRdStrobe = 1;
    @(posedge clk); #1 epRdStrobe = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(4);
    @(negedge clk) check("R1 pin in reset", {31'b0, intPin}, 32'd1);
    @(posedge clk); #1 rst_n = 1;
    phase = "R1";
    rd(8'h21, "R1 mode"); rd(8'h23, "R1 cfg"); rd(8'h25, "R1 enable"); rd(8'h27, "R1 status");
    check("R1 cfg value", expRead(8'h23), 32'd4);

    phase = "R2";
    rd(8'h30, "R2 unknown code");
    rd(8'h20, "R2 write code not readable");
    wr(8'h24, 32'h003F_FFFF);
    wr(8'h20, 32'd1);
    rd(8'h25, "R2 enable readback"); rd(8'h21, "R2 mode readback");
    @(negedge clk) check("R2 idle rdData", rdData, 32'd0);

    phase = "R4";
    gen(5'b01000, '0); idle(4);
    rd(8'h27, "R4 status with event");
    phase = "R7";
    rd(8'h27, "R7 status after clear"); idle(4);

    phase = "R3";
    @(posedge clk); #1 genEvent = 5'b00001; cmd = 8'h27; rdStrobe = 1;
    @(negedge clk) check("R3 read during set", rdData, expRead(8'h27));
    @(posedge clk); #1 genEvent = '0; rdStrobe = 0;
    rd(8'h27, "R3 bit kept on collision");
    rd(8'h27, "R3 cleared afterwards"); idle(3);

    phase = "R8";
    gen('0, 16'h0080); idle(3);
    rd(8'h27, "R8 ep set");
    rd(8'h27, "R8 ep kept after status read");
    epRead(3);
    rd(8'h27, "R8 other index leaves bit");
    epRead(7);
    rd(8'h27, "R8 own index clears"); idle(3);

    phase = "R9";
    @(posedge clk); #1 busStatus = 1;
    rd(8'h27, "R9 live high"); idle(3);
    @(posedge clk); #1 busStatus = 0;
    rd(8'h27, "R9 live low"); idle(3);

    phase = "R4";
    wr(8'h24, 32'h003F_FFEF);
    gen(5'b10000, '0); idle(4);
    rd(8'h27, "R4 disabled bit still logged");
    rd(8'h27, "R4 clear");
    wr(8'h24, 32'h003F_FFFF);

    phase = "R5";
    wr(8'h22, 32'd5);
    gen(5'b00010, '0); idle(4);
    rd(8'h27, "R5 clear"); idle(4);

    phase = "R11";
    wr(8'h20, 32'd0);
    gen(5'b00100, '0); idle(5);
    wr(8'h20, 32'd1); idle(4);
    rd(8'h27, "R11 clear"); idle(4);

    phase = "R6";
    wr(8'h22, 32'd7);
    gen(5'b00001, '0); idle(8);
    rd(8'h27, "R6 clear during pulse"); idle(3);
    gen(5'b00010, '0); idle(6);
    rd(8'h27, "R6 clear again"); idle(PULSE + 10);
    gen(5'b00001, '0); idle(PULSE + 8);
    rd(8'h27, "R6 final clear"); idle(4);

    phase = "R10";
    wr(8'h22, 32'd5);
    gen(5'b01000, '0); idle(4);
    wr(8'h22, 32'd1);
    rd(8'h27, "R10 clear while frozen");
    wr(8'h20, 32'd0); wr(8'h24, 32'd0); idle(4);
    wr(8'h22, 32'd5); idle(4);
    wr(8'h20, 32'd1); wr(8'h24, 32'h003F_FFFF);
    gen(5'b00001, '0); idle(4);
    rd(8'h27, "R10 resumed"); idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual %0d expected <20000 cycles", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule